// File: doc/BRIEF.md
# Multi-Output Clock Enable Controller

This block sits beside a clock fan-out buffer and decides which of its two to four outputs may toggle. Every output has its own enable input. A polarity setting, taken from two strap inputs or from a fixed code chosen when the block is built, decides whether each enable is active high or active low. The enables, the straps and the input-clock-valid flag are asynchronous. They pass through two-flop synchronizers into the control clock domain before they are decoded.

When at least one channel is effectively enabled, the block asserts an active-low clock request, modelled as an open-drain pull-down enable, and a supply enable for the external clock source. It then counts a programmable wake delay before any output may run. A channel that is switched on while the block is already running waits a shorter, separately programmable delay. Gating happens in the source clock domain, with the gate updated on the falling edge, so every output pulse is a whole high phase of the source clock and a disabled output rests at logic low. While the input-clock-valid flag is low, all outputs are suppressed but the request is kept, so the source can come back.

Top module: `clk_en_ctl`

## Requirements
- R1: An output whose channel is not effectively enabled, or any output while reset is applied, is held at logic low.
- R2: `req_pull_low` rises on the third rising edge of `clk_ctl` after the first effective enable becomes active, measured from a change made between edges. It falls on the third edge after the last effective enable goes inactive. It does not depend on `src_valid`.
- R3: `supply_en` follows the same standby/wake condition as the request: it is low while no channel is effectively enabled and high from the start of a wake.
- R4: In pair polarity mode, `strap_in[0]` sets the polarity of the lower half of the channels (channels 0 and 1 of four), and `strap_in[1]` sets the upper half. A strap bit of 1 means active high and 0 means active low.
- R5: In split polarity mode, `strap_in[0]` sets the polarity of channel 0 only, and `strap_in[1]` sets all other channels, with the same 1 = active high encoding.
- R6: In fixed polarity mode, which has three channels, bit 1 of the 2-bit build-time code makes channels 0 and 1 active high, and bit 0 makes channel 2 active high. Code 0 gives all three active low, 1 gives channel 2 high only, 2 gives channels 0 and 1 high, and 3 gives all three high. The straps have no effect in this mode.
- R7: While `src_valid` is low, no output toggles, whatever the enables. Outputs whose enables are active resume once `src_valid` returns high.
- R8: After a wake from standby begins, no output toggles for `WAKE_CYC` control cycles. Enabled outputs start within a few cycles after that.
- R9: A channel enabled while the block is already running produces no pulse for `CH_ON_CYC` control cycles, then starts.
- R10: Channels enabled in the same control cycle produce identical waveforms, with no skew between them.
- R11: Every high pulse on every output lasts exactly one full high phase of `src_clk`; enabling and disabling never shorten a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctl | input | 1 | Control clock for synchronizers, sequencer and delay counters |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| src_clk | input | 1 | Clock from the external source, gated onto the outputs |
| src_valid | input | 1 | High when the amplitude detector sees a usable input clock |
| en_in | input | NUM_CH | Per-channel enable, polarity set by mode and straps |
| strap_in | input | 2 | Board-level polarity straps, 1 = active high |
| clk_out | output | NUM_CH | Gated clock outputs, low when disabled |
| req_pull_low | output | 1 | Drives the open-drain clock request line low when 1 |
| supply_en | output | 1 | Turns on the supply of the external clock source |

## Verification
A sequencer stuck in standby shows as a request that never rises three cycles after an enable. A sequencer stuck running shows as outputs that toggle during the wake window, or while the valid flag is low, within a few tens of control cycles of the stimulus. A wrong polarity decode shows as the wrong set of toggling channels in the next observation window, and the random mix of straps and enables across all three polarity modes exposes it. A wrong gate update edge shows at once as a high pulse shorter than half a source period.

// File: rtl/clk_en_pkg.sv
package clk_en_pkg;
   // how the enable polarity of each channel is chosen
   typedef enum logic [1:0] {
      POL_PAIR  = 2'd0,   // straps split channels into lower and upper halves
      POL_SPLIT = 2'd1,   // strap 0 owns channel 0, strap 1 owns the rest
      POL_FIXED = 2'd2    // build-time code, three channels
   } pol_mode_e;

   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_WAKE  = 2'd1,
      ST_RUN   = 2'd2,
      ST_NOCLK = 2'd3
   } seq_state_e;
endpackage

// File: rtl/clk_en_sync.sv
module clk_en_sync #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/clk_en_polarity.sv
module clk_en_polarity import clk_en_pkg::*; #(
   parameter int         NUM_CH     = 4,
   parameter pol_mode_e  MODE       = POL_PAIR,
   parameter logic [1:0] FIXED_CODE = 2'd0
) (
   input  logic [1:0]        strap,
   input  logic [NUM_CH-1:0] en_s,
   output logic [NUM_CH-1:0] eff
);
   localparam int HALF = NUM_CH / 2;

   if (MODE == POL_FIXED) begin : g_ign
      wire strap_unused = ^strap;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hi;
      if (MODE == POL_FIXED) begin : g_fix
         assign hi = (i < 2) ? FIXED_CODE[1] : FIXED_CODE[0];
      end else if (MODE == POL_PAIR) begin : g_pair
         assign hi = (i < HALF) ? strap[0] : strap[1];
      end else begin : g_split
         assign hi = (i == 0) ? strap[0] : strap[1];
      end
      assign eff[i] = hi ? en_s[i] : ~en_s[i];
   end
endmodule

// File: rtl/clk_en_seq.sv
module clk_en_seq import clk_en_pkg::*; #(
   parameter int NUM_CH    = 4,
   parameter int WAKE_CYC  = 25000,
   parameter int CH_ON_CYC = 250
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed,
   input  logic              valid_s,
   input  logic [NUM_CH-1:0] eff_en,
   output logic              req_on,
   output logic [NUM_CH-1:0] gate_req
);
   localparam int WCW = $clog2(WAKE_CYC + 1);
   localparam int CCW = $clog2(CH_ON_CYC + 1);
   localparam logic [WCW-1:0] WAKE_LAST = WCW'(WAKE_CYC - 1);
   localparam logic [CCW-1:0] CH_DONE   = CCW'(CH_ON_CYC);

   seq_state_e        state;
   logic [WCW-1:0]    wake_cnt;
   logic [NUM_CH-1:0] ch_rdy;
   logic              any_on;

   assign any_on = armed & (|eff_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_OFF;
         wake_cnt <= '0;
      end else if (!any_on) begin
         state    <= ST_OFF;
         wake_cnt <= '0;
      end else begin
         case (state)
            ST_OFF: begin
               state    <= ST_WAKE;
               wake_cnt <= '0;
            end
            ST_WAKE: begin
               if (wake_cnt == WAKE_LAST) state <= valid_s ? ST_RUN : ST_NOCLK;
               else                       wake_cnt <= wake_cnt + 1'b1;
            end
            ST_RUN:   if (!valid_s) state <= ST_NOCLK;
            ST_NOCLK: if (valid_s)  state <= ST_RUN;
            default:  state <= ST_OFF;
         endcase
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [CCW-1:0] on_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     on_cnt <= '0;
         else if (!(armed && eff_en[i])) on_cnt <= '0;
         else if (on_cnt != CH_DONE)     on_cnt <= on_cnt + 1'b1;
      end
      assign ch_rdy[i] = (on_cnt == CH_DONE);

      // R9: a channel only becomes ready after being enabled
      assert_ch_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_rdy[i]) |-> $past(armed && eff_en[i]));
   end

   assign req_on   = (state != ST_OFF);
   assign gate_req = (state == ST_RUN) ? (ch_rdy & eff_en) : '0;

   assert_off_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !any_on |=> state == ST_OFF);
   assert_wake_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF && any_on) |=> state == ST_WAKE);
   assert_noclk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_s && state != ST_OFF) |=> state != ST_RUN);
   assert_wake_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && $past(state) == ST_WAKE) |-> $past(wake_cnt) == WAKE_LAST);
endmodule

// File: rtl/clk_en_gate.sv
module clk_en_gate #(
   parameter int NUM_CH = 4
) (
   input  logic              src_clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] gate_req,
   output logic [NUM_CH-1:0] clk_out
);
   logic [NUM_CH-1:0] gate_s;
   logic [NUM_CH-1:0] gate_n;

   clk_en_sync #(.W(NUM_CH)) u_src_sync (
      .clk   (src_clk),
      .rst_n (rst_n),
      .d     (gate_req),
      .q     (gate_s)
   );

   // the gate changes only while src_clk is low, so no pulse is cut short
   always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n) gate_n <= '0;
      else        gate_n <= gate_s;
   end

   assign clk_out = gate_n & {NUM_CH{src_clk}};

   assert_gate_follow_R11: assert property (@(negedge src_clk) disable iff (!rst_n)
      gate_s != $past(gate_s) |=> gate_n == $past(gate_s));
endmodule

// File: rtl/clk_en_ctl.sv
module clk_en_ctl import clk_en_pkg::*; #(
   parameter int         NUM_CH     = 4,
   parameter pol_mode_e  POL_MODE   = POL_PAIR,
   parameter logic [1:0] FIXED_CODE = 2'd0,
   parameter int         WAKE_CYC   = 25000,
   parameter int         CH_ON_CYC  = 250
) (
   input  logic              clk_ctl,
   input  logic              rst_n,
   input  logic              src_clk,
   input  logic              src_valid,
   input  logic [NUM_CH-1:0] en_in,
   input  logic [1:0]        strap_in,
   output logic [NUM_CH-1:0] clk_out,
   output logic              req_pull_low,
   output logic              supply_en
);
   localparam int SW = NUM_CH + 3;

   if (NUM_CH < 2 || NUM_CH > 4) begin : g_bad_ch
      $error("clk_en_ctl: NUM_CH must be 2 to 4");
   end
   if (POL_MODE == POL_FIXED && NUM_CH != 3) begin : g_bad_fix
      $error("clk_en_ctl: fixed polarity needs three channels");
   end
   if (WAKE_CYC < 2 || CH_ON_CYC < 1) begin : g_bad_dly
      $error("clk_en_ctl: delays out of range");
   end

   logic [SW-1:0]     sync_q;
   logic [NUM_CH-1:0] en_s;
   logic [NUM_CH-1:0] eff;
   logic [NUM_CH-1:0] gate_req;
   logic [1:0]        strap_s;
   logic              valid_s;
   logic [1:0]        warm;
   logic              req_on;

   clk_en_sync #(.W(SW)) u_in_sync (
      .clk   (clk_ctl),
      .rst_n (rst_n),
      .d     ({src_valid, strap_in, en_in}),
      .q     (sync_q)
   );
   assign en_s    = sync_q[NUM_CH-1:0];
   assign strap_s = sync_q[NUM_CH +: 2];
   assign valid_s = sync_q[SW-1];

   // decoding waits until the synchronizers hold real input values
   always_ff @(posedge clk_ctl or negedge rst_n) begin
      if (!rst_n) warm <= '0;
      else        warm <= {warm[0], 1'b1};
   end

   clk_en_polarity #(.NUM_CH(NUM_CH), .MODE(POL_MODE), .FIXED_CODE(FIXED_CODE)) u_pol (
      .strap (strap_s),
      .en_s  (en_s),
      .eff   (eff)
   );

   clk_en_seq #(.NUM_CH(NUM_CH), .WAKE_CYC(WAKE_CYC), .CH_ON_CYC(CH_ON_CYC)) u_seq (
      .clk      (clk_ctl),
      .rst_n    (rst_n),
      .armed    (warm[1]),
      .valid_s  (valid_s),
      .eff_en   (eff),
      .req_on   (req_on),
      .gate_req (gate_req)
   );

   clk_en_gate #(.NUM_CH(NUM_CH)) u_gate (
      .src_clk  (src_clk),
      .rst_n    (rst_n),
      .gate_req (gate_req),
      .clk_out  (clk_out)
   );

   assign req_pull_low = req_on;
   assign supply_en    = req_on;

   assert_req_release_R2: assert property (@(posedge clk_ctl) disable iff (!rst_n)
      !(warm[1] && |eff) |=> !req_pull_low);
   assert_gate_needs_req_R1: assert property (@(posedge clk_ctl) disable iff (!rst_n)
      |gate_req |-> supply_en);
endmodule

// File: tb/test_clk_en_ctl.sv
`timescale 1ns/1ps
module test_clk_en_ctl;
   import clk_en_pkg::*;
   localparam int WAKE = 40;
   localparam int CHON = 8;
   localparam int NB   = 20;

   logic clk = 0, src_clk = 0, rst_n = 0, src_valid = 1;
   logic [3:0] en_a = 0, en_b = 0;
   logic [2:0] en_f = 0;
   logic [1:0] strap = 2'b11;
   wire  [3:0] out_a, out_b;
   wire  [11:0] out_f;
   wire  pl_a, se_a, pl_b, se_b;
   wire  [3:0] pl_f, se_f;
   wire  [NB-1:0] all_out = {out_f, out_b, out_a};

   int n_chk = 0, n_fail = 0, bad_pulse = 0, skew_bad = 0;
   bit skew_on = 0, done = 0;
   int tog [NB];
   realtime t_rise [NB];

   always #10 clk = ~clk;
   always #7  src_clk = ~src_clk;

   clk_en_ctl #(.NUM_CH(4), .POL_MODE(POL_PAIR), .WAKE_CYC(WAKE), .CH_ON_CYC(CHON)) i_clk_en_ctl (
      .clk_ctl(clk), .rst_n(rst_n), .src_clk(src_clk), .src_valid(src_valid), .en_in(en_a),
      .strap_in(strap), .clk_out(out_a), .req_pull_low(pl_a), .supply_en(se_a));
   clk_en_ctl #(.NUM_CH(4), .POL_MODE(POL_SPLIT), .WAKE_CYC(WAKE), .CH_ON_CYC(CHON)) i_clk_en_ctl_split (
      .clk_ctl(clk), .rst_n(rst_n), .src_clk(src_clk), .src_valid(src_valid), .en_in(en_b),
      .strap_in(strap), .clk_out(out_b), .req_pull_low(pl_b), .supply_en(se_b));
   for (genvar c = 0; c < 4; c++) begin : g_fix
      clk_en_ctl #(.NUM_CH(3), .POL_MODE(POL_FIXED), .FIXED_CODE(2'(c)), .WAKE_CYC(WAKE),
                   .CH_ON_CYC(CHON)) i_clk_en_ctl_fix (
         .clk_ctl(clk), .rst_n(rst_n), .src_clk(src_clk), .src_valid(src_valid), .en_in(en_f),
         .strap_in(strap), .clk_out(out_f[3*c +: 3]), .req_pull_low(pl_f[c]), .supply_en(se_f[c]));
   end

   for (genvar k = 0; k < NB; k++) begin : g_mon
      always @(posedge all_out[k]) begin
         tog[k]++;
         t_rise[k] = $realtime;
      end
      always @(negedge all_out[k]) begin
         realtime w;
         w = $realtime - t_rise[k];
         if (w < 6.99 || w > 7.01) bad_pulse++;
      end
   end

   always @(posedge src_clk) begin
      #1;
      if (skew_on && out_a[2] != out_a[3]) skew_bad++;
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr();
      for (int k = 0; k < NB; k++) tog[k] = 0;
   endtask

   // effective enable per observed output, from R4, R5 and R6
   function automatic logic [NB-1:0] expect_on(logic [1:0] s, logic [3:0] a, logic [3:0] b, logic [2:0] f);
      logic [NB-1:0] r;
      for (int i = 0; i < 4; i++) begin
         logic ha, hb;
         ha = (i < 2) ? s[0] : s[1];
         hb = (i == 0) ? s[0] : s[1];
         r[i]     = ha ? a[i] : ~a[i];
         r[4 + i] = hb ? b[i] : ~b[i];
      end
      for (int c = 0; c < 4; c++)
         for (int i = 0; i < 3; i++) begin
            logic hf;
            hf = (i < 2) ? c[1] : c[0];
            r[8 + 3*c + i] = hf ? f[i] : ~f[i];
         end
      return r;
   endfunction

   initial begin
      #3ms;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [NB-1:0] ex;
      int unsigned seed;
      seed = $urandom(32'd7741);
      clr();
      cyc(5);
      // R1 reset state
      chk(out_a == 0 && out_b == 0, "R1", "outputs in reset", int'({out_b, out_a}), 0);
      chk(!pl_a && !se_a, "R2", "request in reset", int'(pl_a), 0);
      rst_n = 1;
      cyc(10);
      chk(!pl_a && !pl_b, "R2", "request idle", int'({pl_b, pl_a}), 0);
      chk(!se_a && !se_b, "R3", "supply idle", int'({se_b, se_a}), 0);
      chk(tog[0] + tog[1] + tog[2] + tog[3] == 0, "R1", "idle toggles", tog[0], 0);

      // R2 and R8: wake from standby on channel 0 of the pair instance
      en_a = 4'b0001;
      clr();
      cyc(2);
      chk(!pl_a, "R2", "request before third edge", int'(pl_a), 0);
      cyc(1);
      chk(pl_a, "R2", "request on third edge", int'(pl_a), 1);
      chk(se_a, "R3", "supply on at wake", int'(se_a), 1);
      cyc(WAKE - 1);
      chk(tog[0] == 0, "R8", "no pulse during wake", tog[0], 0);
      cyc(8);
      chk(tog[0] > 0, "R8", "pulses after wake", tog[0], 1);
      chk(tog[1] + tog[2] + tog[3] == 0, "R1", "other channels quiet", tog[1] + tog[2] + tog[3], 0);

      // R9: channel 1 enabled while running
      en_a = 4'b0011;
      clr();
      cyc(CHON + 1);
      chk(tog[1] == 0, "R9", "no pulse within on delay", tog[1], 0);
      cyc(8);
      chk(tog[1] > 0, "R9", "pulses after on delay", tog[1], 1);

      // R10: channels 2 and 3 enabled together
      en_a = 4'b1111;
      clr();
      skew_on = 1;
      cyc(30);
      skew_on = 0;
      chk(skew_bad == 0, "R10", "skew mismatches", skew_bad, 0);
      chk(tog[2] > 0 && tog[2] == tog[3], "R10", "pulse count ch3", tog[3], tog[2]);

      // R7: missing input clock
      src_valid = 0;
      cyc(8);
      clr();
      cyc(20);
      chk(tog[0] + tog[1] + tog[2] + tog[3] == 0, "R7", "toggles without valid", tog[0] + tog[3], 0);
      chk(pl_a, "R7", "request kept without valid", int'(pl_a), 1);
      src_valid = 1;
      cyc(12);
      clr();
      cyc(20);
      chk(tog[0] > 0 && tog[3] > 0, "R7", "resume after valid", tog[3], 1);

      // R2, R3, R1: all channels off
      en_a = 4'b0000;
      cyc(2);
      chk(pl_a, "R2", "request held two edges", int'(pl_a), 1);
      cyc(1);
      chk(!pl_a && !se_a, "R3", "standby after last enable", int'({se_a, pl_a}), 0);
      cyc(8);
      clr();
      cyc(20);
      chk(out_a == 0 && tog[0] + tog[1] + tog[2] + tog[3] == 0, "R1", "disabled outputs low", int'(out_a), 0);

      // R4, R5, R6: random straps and enables
      for (int it = 0; it < 25; it++) begin
         strap = 2'($urandom);
         en_a  = 4'($urandom);
         en_b  = 4'($urandom);
         en_f  = 3'($urandom);
         if (it == 0) begin strap = 2'b00; en_a = 4'b1111; en_b = 4'b1111; en_f = 3'b111; end
         cyc(WAKE + CHON + 12);
         clr();
         cyc(20);
         ex = expect_on(strap, en_a, en_b, en_f);
         for (int k = 0; k < NB; k++) begin
            string rq;
            rq = (k < 4) ? "R4" : (k < 8) ? "R5" : "R6";
            chk((tog[k] > 0) == ex[k], rq, $sformatf("channel %0d activity", k), int'(tog[k] > 0), int'(ex[k]));
         end
         chk(pl_a == |ex[3:0], "R2", "pair request", int'(pl_a), int'(|ex[3:0]));
         chk(pl_b == |ex[7:4], "R2", "split request", int'(pl_b), int'(|ex[7:4]));
         for (int c = 0; c < 4; c++)
            chk(pl_f[c] == |ex[8 + 3*c +: 3], "R6", "fixed request", int'(pl_f[c]), int'(|ex[8 + 3*c +: 3]));
      end

      chk(bad_pulse == 0, "R11", "short pulses", bad_pulse, 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule